// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block puts the command behaviour of a parallel NOR flash in front of a small on-chip word RAM. Every write that reaches it is treated as a command cycle. The low byte of the write data is decoded according to the current phase of a multi-cycle sequence. The supported sequences are single program, sector erase with confirm, lock/unlock, status clear, status and identifier read latching, query entry and buffered write. Reads return either array data, the 8-bit status register, or zero while the identifier or query mode is active. In those two modes a separate formatter, selected through `ident_mode`, supplies the real response.

Requests arrive on a valid/ready channel and each one produces exactly one response on a second valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only when the response slot is free or is being drained in the same cycle, and no erase is running. The response for an accepted request appears on the following cycle and is held unchanged until `rsp_ready` is seen high. The one exception is an erase: its response waits until every word of the sector has been filled. A write-protect input suppresses all array modification. An optional secure mode rejects writes that lack the secure attribute.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, `ident_mode` is 0, the sequence is idle in array mode and the status register is 0x00.
- R2: In the idle phase, command bytes 0x00, 0xF0, 0xFF and any unrecognised byte return to array mode, so later reads return array data.
- R3: Command 0x10 or 0x40 arms one program. The next write stores its data at its address and sets status bit 7. Reads then return status until another command is given.
- R4: While `wr_protect` is 1, a program data write leaves the array unchanged and sets status bits 7 and 4.
- R5: Command 0x20 fills the whole sector holding the address (the address aligned down to SECTOR_BYTES) with 0xFF and sets status bit 7. The response comes SECTOR_BYTES/4 cycles later than a normal write, and `req_ready` stays low during that time. Under `wr_protect` nothing is erased, status bits 7 and 5 are set, and the response is not delayed.
- R6: The cycle after 0x20 must carry 0xD0, which sets status bit 7 and leaves reads returning status. Any other byte in that cycle, 0xFF included, returns to array mode.
- R7: Command 0x50 clears the status register to 0x00 and returns to array mode. Commands 0x70 and 0x90 are latched without leaving the idle phase, so the next write is decoded as a new command.
- R8: Command 0x60 followed by 0xD0 or 0x01 sets status bit 7 and leaves status reads. Any other second byte returns to array mode.
- R9: Command 0xE8 sets status bit 7. The next write gives a word count, masked to 8*DEV_BYTES bits (8*BANK_BYTES when DEV_BYTES is 0). The count is followed by count+1 data writes, each stored at its own address. A final 0xD0 sets bit 7; any other final byte returns to array mode and keeps the stored data.
- R10: Reads return status while the latched command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8. They return 0 while it is 0x90 (with `ident_mode` = 2'b01) or 0x98 (with `ident_mode` = 2'b10). Otherwise they return array data with `ident_mode` = 2'b00. Status occupies bits 7:0 of the read data, and reads never change the status register.
- R11: With SECURE_EN set, a write with `req_secure` low is answered with `rsp_err` = 1 and has no effect. A read with `req_secure` low returns array data whatever the command state.
- R12: `req_size` 0/1/2 selects a 1/2/4-byte access, aligned by ignoring the low address bits. Byte k of the value maps to address offset k when BIG_ENDIAN is 0 and to offset n-1-k when it is 1; reads use the same order.
- R13: Every accepted request yields one response. While `rsp_valid` is high and `rsp_ready` is low, the response data and error stay stable and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_protect | input | 1 | Blocks program and erase of the array |
| ident_mode | output | 2 | 01 identifier mode, 10 query mode, 00 otherwise |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | $clog2(MEM_BYTES) | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write value; bits 7:0 are the command byte |
| req_secure | input | 1 | Secure access attribute |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Rejected non-secure write |

## Verification
The bench uses a confirm byte other than 0xD0 after an erase, and it checks that reads revert to array data. A design that kept status mode here would return 0x80 instead of array words. An erase is placed at an unaligned address between two previously programmed words, to catch an erase that fills the wrong sector or touches its neighbour. A buffered write is given a count whose upper half must be masked away; an unmasked count would never reach the confirm phase. Non-secure writes that would clear status, and non-secure reads in status mode, expose a design that lets the attribute leak into the sequence. The bench also stalls a read response, which shows whether the data drifts or a second request slips in.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [7:0] C_RESET     = 8'h00;
  localparam logic [7:0] C_ALT_RESET = 8'hF0;
  localparam logic [7:0] C_ARRAY     = 8'hFF;
  localparam logic [7:0] C_PROG_A    = 8'h10;
  localparam logic [7:0] C_PROG_B    = 8'h40;
  localparam logic [7:0] C_ERASE     = 8'h20;
  localparam logic [7:0] C_ERASE_ALT = 8'h28;
  localparam logic [7:0] C_CLR       = 8'h50;
  localparam logic [7:0] C_LOCK      = 8'h60;
  localparam logic [7:0] C_RSTAT     = 8'h70;
  localparam logic [7:0] C_RID       = 8'h90;
  localparam logic [7:0] C_QRY       = 8'h98;
  localparam logic [7:0] C_BUF       = 8'hE8;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;
  localparam logic [7:0] C_LOCK_ALT  = 8'h01;

  localparam int ST_DONE = 7;
  localparam int ST_ERS  = 5;
  localparam int ST_PRG  = 4;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_ZERO} rd_src_e;
  typedef enum logic [1:0] {PH_CMD, PH_ARG, PH_DATA, PH_CONF} phase_e;

  function automatic bit shows_status(logic [7:0] c);
    return c inside {C_PROG_A, C_ERASE, C_ERASE_ALT, C_PROG_B, C_CLR,
                     C_LOCK, C_RSTAT, C_BUF};
  endfunction

  function automatic bit cmd_known(logic [7:0] c);
    return shows_status(c) || c == C_RESET || c == C_RID || c == C_QRY;
  endfunction

endpackage

// File: rtl/nor_lane_map.sv
module nor_lane_map #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [1:0]  w_size,
  input  logic [1:0]  w_off,
  input  logic [31:0] w_data,
  output logic [3:0]  w_be,
  output logic [31:0] w_lanes,
  input  logic [1:0]  r_size,
  input  logic [1:0]  r_off,
  input  logic [31:0] r_word,
  output logic [31:0] r_data
);

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [1:0] align_off(logic [1:0] s, logic [1:0] o);
    return (s == 2'd0) ? o : (s == 2'd1) ? {o[1], 1'b0} : 2'b00;
  endfunction

  function automatic logic [1:0] lane_of(logic [1:0] s, logic [1:0] o, int k);
    int idx;
    idx = BIG_ENDIAN ? (nbytes(s) - 1 - k) : k;
    return align_off(s, o) + idx[1:0];
  endfunction

  always_comb begin
    w_be    = '0;
    w_lanes = '0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ln;
      ln = lane_of(w_size, w_off, k);
      if (k < nbytes(w_size)) begin
        w_lanes[{ln, 3'b000} +: 8] = w_data[k*8 +: 8];
        w_be[ln] = 1'b1;
      end
    end
  end

  always_comb begin
    r_data = '0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ln;
      ln = lane_of(r_size, r_off, k);
      if (k < nbytes(r_size)) r_data[k*8 +: 8] = r_word[{ln, 3'b000} +: 8];
    end
  end

endmodule

// File: rtl/nor_word_ram.sv
module nor_word_ram #(
  parameter int WORDS = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic [3:0]    we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*8 +: 8];
      if (re) q <= mem[addr];
    end
    assign rdata[g*8 +: 8] = q;
  end

endmodule

// File: rtl/nor_erase_walker.sv
module nor_erase_walker #(
  parameter int WAW       = 8,
  parameter int SEC_WORDS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [WAW-1:0] start_word,
  output logic           busy,
  output logic [WAW-1:0] waddr,
  output logic           done
);

  localparam int CW = (SEC_WORDS > 1) ? $clog2(SEC_WORDS) : 1;
  localparam logic [WAW-1:0] SEC_MASK = WAW'(SEC_WORDS - 1);
  localparam logic [CW-1:0]  LAST     = CW'(SEC_WORDS - 1);

  logic [CW-1:0]  cnt_q;
  logic [WAW-1:0] base_q;
  logic           busy_q;

  assign busy  = busy_q;
  assign done  = busy_q && (cnt_q == LAST);
  assign waddr = base_q | WAW'(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= start_word & ~SEC_MASK;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic             rd_evt,
  input  logic [7:0]       wr_byte,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wp,
  output logic             prog_en,
  output logic             erase_en,
  output rd_src_e          rd_src,
  output logic [1:0]       ident_mode,
  output logic [7:0]       status,
  output phase_e           phase
);

  logic [7:0]       cmd_q, cmd_d;
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       st_q, st_d;

  assign status = st_q;
  assign phase  = ph_q;

  always_comb begin
    if (shows_status(cmd_q))                    rd_src = SRC_STATUS;
    else if (cmd_q == C_RID || cmd_q == C_QRY)  rd_src = SRC_ZERO;
    else                                        rd_src = SRC_ARRAY;
    ident_mode = (cmd_q == C_RID) ? 2'b01 : (cmd_q == C_QRY) ? 2'b10 : 2'b00;
  end

  always_comb begin
    cmd_d    = cmd_q;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    st_d     = st_q;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    if (rd_evt && !cmd_known(cmd_q)) begin
      cmd_d = C_RESET;
      ph_d  = PH_CMD;
    end
    if (wr_evt) begin
      case (ph_q)
        PH_CMD: begin
          case (wr_byte)
            C_PROG_A, C_PROG_B, C_LOCK, C_QRY: begin
              cmd_d = wr_byte;
              ph_d  = PH_ARG;
            end
            C_ERASE: begin
              erase_en = !wp;
              if (wp) st_d[ST_ERS] = 1'b1;
              st_d[ST_DONE] = 1'b1;
              cmd_d = wr_byte;
              ph_d  = PH_ARG;
            end
            C_BUF: begin
              st_d[ST_DONE] = 1'b1;
              cmd_d = wr_byte;
              ph_d  = PH_ARG;
            end
            C_RSTAT, C_RID: cmd_d = wr_byte;
            C_CLR: begin
              st_d  = '0;
              cmd_d = C_RESET;
            end
            default: cmd_d = C_RESET;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            C_PROG_A, C_PROG_B: begin
              prog_en = !wp;
              if (wp) st_d[ST_PRG] = 1'b1;
              st_d[ST_DONE] = 1'b1;
              ph_d = PH_CMD;
            end
            C_ERASE, C_ERASE_ALT: begin
              ph_d = PH_CMD;
              if (wr_byte == C_CONFIRM) st_d[ST_DONE] = 1'b1;
              else cmd_d = C_RESET;
            end
            C_LOCK: begin
              ph_d = PH_CMD;
              if (wr_byte == C_CONFIRM || wr_byte == C_LOCK_ALT) st_d[ST_DONE] = 1'b1;
              else cmd_d = C_RESET;
            end
            C_BUF: begin
              cnt_d = wr_count;
              ph_d  = PH_DATA;
            end
            C_QRY: begin
              if (wr_byte == C_ARRAY) begin
                cmd_d = C_RESET;
                ph_d  = PH_CMD;
              end
            end
            default: begin
              cmd_d = C_RESET;
              ph_d  = PH_CMD;
            end
          endcase
        end
        PH_DATA: begin
          if (cmd_q == C_BUF) begin
            prog_en = !wp;
            if (wp) st_d[ST_PRG] = 1'b1;
            st_d[ST_DONE] = 1'b1;
            if (cnt_q == '0) ph_d = PH_CONF;
            cnt_d = cnt_q - 1'b1;
          end else begin
            cmd_d = C_RESET;
            ph_d  = PH_CMD;
          end
        end
        default: begin
          ph_d = PH_CMD;
          if (cmd_q == C_BUF && wr_byte == C_CONFIRM) st_d[ST_DONE] = 1'b1;
          else cmd_d = C_RESET;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= C_RESET;
      ph_q  <= PH_CMD;
      cnt_q <= '0;
      st_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int SECTOR_BYTES = 64,
  parameter int DEV_BYTES    = 2,
  parameter int BANK_BYTES   = 2,
  parameter bit BIG_ENDIAN   = 1'b0,
  parameter bit SECURE_EN    = 1'b1,
  localparam int AW          = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_protect,
  output logic [1:0]    ident_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic          req_secure,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err
);

  localparam int WAW       = AW - 2;
  localparam int WORDS     = MEM_BYTES / 4;
  localparam int SEC_WORDS = SECTOR_BYTES / 4;
  localparam int CNT_BYTES = (DEV_BYTES != 0) ? DEV_BYTES : BANK_BYTES;
  localparam int CNT_W     = 8 * CNT_BYTES;

  logic          acc, sec_ok, wr_evt, rd_evt;
  logic          prog_en, erase_en;
  rd_src_e       fsm_src, src_q;
  logic [7:0]    fsm_status, stat_snap_q;
  phase_e        fsm_phase;
  logic          walk_busy, walk_done;
  logic [WAW-1:0] walk_addr, ram_addr;
  logic [3:0]    w_be, ram_we;
  logic [31:0]   w_lanes, ram_wdata, ram_rdata, lane_rdata;
  logic [1:0]    r_off_q, r_size_q;
  logic          rsp_valid_q, rsp_err_q;

  assign sec_ok    = !SECURE_EN || req_secure;
  assign req_ready = (!rsp_valid_q || rsp_ready) && !walk_busy;
  assign acc       = req_valid && req_ready;
  assign wr_evt    = acc && req_write && sec_ok;
  assign rd_evt    = acc && !req_write && sec_ok;

  nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_evt     (wr_evt),
    .rd_evt     (rd_evt),
    .wr_byte    (req_wdata[7:0]),
    .wr_count   (req_wdata[CNT_W-1:0]),
    .wp         (wr_protect),
    .prog_en    (prog_en),
    .erase_en   (erase_en),
    .rd_src     (fsm_src),
    .ident_mode (ident_mode),
    .status     (fsm_status),
    .phase      (fsm_phase)
  );

  nor_erase_walker #(.WAW(WAW), .SEC_WORDS(SEC_WORDS)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (erase_en),
    .start_word (req_addr[AW-1:2]),
    .busy       (walk_busy),
    .waddr      (walk_addr),
    .done       (walk_done)
  );

  nor_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_lanes (
    .w_size  (req_size),
    .w_off   (req_addr[1:0]),
    .w_data  (req_wdata),
    .w_be    (w_be),
    .w_lanes (w_lanes),
    .r_size  (r_size_q),
    .r_off   (r_off_q),
    .r_word  (ram_rdata),
    .r_data  (lane_rdata)
  );

  assign ram_addr  = walk_busy ? walk_addr : req_addr[AW-1:2];
  assign ram_we    = walk_busy ? 4'hF : (prog_en ? w_be : 4'h0);
  assign ram_wdata = walk_busy ? 32'hFFFF_FFFF : w_lanes;

  nor_word_ram #(.WORDS(WORDS), .AW(WAW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (acc && !req_write),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      src_q       <= SRC_ZERO;
      stat_snap_q <= '0;
      r_off_q     <= '0;
      r_size_q    <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if ((acc && !erase_en) || walk_done) rsp_valid_q <= 1'b1;
      if (acc) begin
        rsp_err_q   <= req_write && !sec_ok;
        src_q       <= req_write ? SRC_ZERO : (sec_ok ? fsm_src : SRC_ARRAY);
        stat_snap_q <= fsm_status;
        r_off_q     <= req_addr[1:0];
        r_size_q    <= req_size;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  always_comb begin
    case (src_q)
      SRC_ARRAY:  rsp_rdata = lane_rdata;
      SRC_STATUS: rsp_rdata = {24'h0, stat_snap_q};
      default:    rsp_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter bit SECURE_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        req_secure,
  input logic [7:0]  cmd_byte,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic [1:0]  ident_mode,
  input logic        busy,
  input logic [7:0]  status,
  input logic [1:0]  phase
);

  logic take;
  assign take = req_valid && req_ready;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R13

  AST_ERASE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R5

  AST_SEC_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (SECURE_EN && take && req_write && !req_secure) |=> (rsp_valid && rsp_err)); // R11

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_write && (req_secure || !SECURE_EN) && phase == 2'd0 && cmd_byte == 8'h50)
      |=> (status == 8'h00)); // R7

  AST_IDENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ident_mode)); // R10

  AST_READ_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_write) |=> $stable(status)); // R10

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.SECURE_EN(SECURE_EN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_secure (req_secure),
  .cmd_byte   (req_wdata[7:0]),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .ident_mode (ident_mode),
  .busy       (walk_busy),
  .status     (fsm_status),
  .phase      (fsm_phase)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

  localparam int MEMB = 1024;
  localparam int SECB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_protect = 1'b0;
  logic [1:0]  ident_mode;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_lat = 0;
  bit finished = 0;

  logic [7:0] mm [MEMB];
  int m_stat = 0, m_cmd = 0, m_ph = 0, m_cnt = 0;

  always #2 clk = ~clk;

  nor_cmd_seq #(.MEM_BYTES(MEMB), .SECTOR_BYTES(SECB), .DEV_BYTES(2),
                .BANK_BYTES(2), .BIG_ENDIAN(1'b0), .SECURE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .ident_mode(ident_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_arr(input int a, input int sz);
    logic [31:0] v = 0;
    int al = a & ~(sz - 1);
    for (int k = 0; k < sz; k++) v[k*8 +: 8] = mm[al + k];
    return v;
  endfunction

  function automatic logic [1:0] m_ident();
    return (m_cmd == 'h90) ? 2'b01 : (m_cmd == 'h98) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [31:0] m_read_exp(input int a, input int sz, input bit sec);
    if (!sec) return m_arr(a, sz);
    case (m_cmd)
      'h10, 'h20, 'h28, 'h40, 'h50, 'h60, 'h70, 'hE8: return m_stat;
      'h90, 'h98: return 0;
      default: return m_arr(a, sz);
    endcase
  endfunction

  task automatic m_idle();
    m_cmd = 0;
    m_ph = 0;
  endtask

  task automatic m_store(input int a, input logic [31:0] d, input int sz);
    int al = a & ~(sz - 1);
    if (wr_protect) m_stat |= 'h10;
    else for (int k = 0; k < sz; k++) mm[al + k] = d[k*8 +: 8];
    m_stat |= 'h80;
  endtask

  task automatic m_write(input int a, input logic [31:0] d, input int sz);
    int c = int'(d[7:0]);
    case (m_ph)
      0: case (c)
        'h10, 'h40, 'h60, 'h98: begin m_cmd = c; m_ph = 1; end
        'h20: begin
          if (wr_protect) m_stat |= 'h20;
          else for (int i = 0; i < SECB; i++) mm[(a & ~(SECB - 1)) + i] = 8'hFF;
          m_stat |= 'h80; m_cmd = c; m_ph = 1;
        end
        'hE8: begin m_stat |= 'h80; m_cmd = c; m_ph = 1; end
        'h70, 'h90: m_cmd = c;
        'h50: begin m_stat = 0; m_idle(); end
        default: m_idle();
      endcase
      1: case (m_cmd)
        'h10, 'h40: begin m_store(a, d, sz); m_ph = 0; end
        'h20: if (c == 'hD0) begin m_stat |= 'h80; m_ph = 0; end else m_idle();
        'h60: if (c == 'hD0 || c == 'h01) begin m_stat |= 'h80; m_ph = 0; end else m_idle();
        'hE8: begin m_cnt = int'(d[15:0]); m_ph = 2; end
        'h98: if (c == 'hFF) m_idle();
        default: m_idle();
      endcase
      2: begin
        m_store(a, d, sz);
        if (m_cnt == 0) m_ph = 3;
        m_cnt = (m_cnt - 1) & 'hFFFF;
      end
      default: if (c == 'hD0) begin m_stat |= 'h80; m_ph = 0; end else m_idle();
    endcase
  endtask

  task automatic xact(input bit w, input int a, input logic [31:0] d, input int sz,
                      input bit sec, input string tag);
    logic [31:0] exp_d;
    bit exp_e;
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a[9:0]; req_wdata = d;
    req_size = (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : 2'd2; req_secure = sec;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_d = 0;
    exp_e = 0;
    if (w) begin
      exp_e = !sec;
      if (sec) m_write(a, d, sz);
    end else exp_d = m_read_exp(a, sz, sec);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    last_lat = lat;
    chk(tag, "rsp_err", {31'h0, rsp_err}, {31'h0, exp_e});
    if (!w) chk(tag, "rsp_rdata", rsp_rdata, exp_d);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    xact(1'b1, a, d, 4, 1'b1, tag);
  endtask

  task automatic rd(input int a, input int sz, input string tag);
    xact(1'b0, a, 0, sz, 1'b1, tag);
  endtask

  // per-clock comparison of the mode output against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      checks++;
      if (ident_mode !== m_ident()) begin
        fails++;
        $display("FAIL R10 ident_mode act=%h exp=%h", ident_mode, m_ident());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1", "req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1", "ident_mode", {30'h0, ident_mode}, 32'h0);
    wr(0, 'h70, "R1");
    rd(0, 4, "R1");

    // fill the whole array
    for (int s = 0; s < MEMB / SECB; s++) begin
      wr(s * SECB, 'h20, "R5");
      chk("R5", "erase latency", last_lat, SECB / 4);
      wr(s * SECB, 'hD0, "R6");
    end
    rd(8, 4, "R6");
    wr(0, 'hFF, "R6");
    rd(8, 4, "R5");
    wr(0, 'h50, "R7");

    // program and byte order
    wr(0, 'h40, "R3");
    wr('h100, 'h11223344, "R3");
    rd('h100, 4, "R3");
    wr(0, 'hFF, "R2");
    rd('h100, 4, "R12");
    rd('h101, 1, "R12");
    rd('h102, 2, "R12");
    wr(0, 'h10, "R3");
    xact(1'b1, 'h106, 'h0000BEEF, 2, 1'b1, "R12");
    wr(0, 'hF0, "R2");
    rd('h106, 1, "R12");
    rd('h104, 4, "R12");
    wr(0, 'h40, "R12");
    xact(1'b1, 'h10B, 'h000000A7, 1, 1'b1, "R12");
    wr(0, 'h00, "R2");
    rd('h108, 4, "R12");

    // erase alignment around sector 1
    wr(0, 'h40, "R5"); wr('h7C, 'hCAFEF00D, "R5");
    wr(0, 'h40, "R5"); wr('h80, 'h0BADBEEF, "R5");
    wr(0, 'hFF, "R5");
    wr('h45, 'h20, "R5");
    chk("R5", "erase latency", last_lat, SECB / 4);
    wr(0, 'h33, "R6");
    rd('h7C, 4, "R5");
    rd('h80, 4, "R5");
    rd('h40, 4, "R6");
    wr('h3C4, 'h20, "R5");
    wr(0, 'hFF, "R6");
    rd('h3C4, 4, "R6");

    // status clear and latching
    wr(0, 'h50, "R7");
    rd('h100, 4, "R7");
    wr(0, 'h70, "R7");
    rd(0, 4, "R7");
    wr(0, 'h90, "R7");
    rd('h100, 4, "R10");
    wr(0, 'h40, "R7");
    wr('h200, 'hA5A55A5A, "R7");
    wr(0, 'hFF, "R7");
    rd('h200, 4, "R7");
    wr(0, 'h98, "R10");
    rd(0, 4, "R10");
    wr(0, 'h12, "R10");
    rd(4, 4, "R10");
    wr(0, 'hFF, "R10");
    rd('h200, 2, "R10");

    // write protection
    wr(0, 'h50, "R4");
    wr_protect = 1'b1;
    wr(0, 'h10, "R4");
    wr('h100, 'h0, "R4");
    rd(0, 4, "R4");
    wr(0, 'hFF, "R4");
    rd('h100, 4, "R4");
    wr('h100, 'h20, "R5");
    chk("R5", "protected erase latency", last_lat, 0);
    rd(0, 4, "R5");
    wr(0, 'hD0, "R5");
    wr(0, 'hFF, "R5");
    rd('h100, 4, "R5");
    wr(0, 'h50, "R4");
    wr_protect = 1'b0;

    // lock sequences
    wr(0, 'h60, "R8"); wr(0, 'h01, "R8"); rd(0, 4, "R8");
    wr(0, 'h50, "R8");
    wr(0, 'h60, "R8"); wr(0, 'hD0, "R8"); rd(0, 4, "R8");
    wr(0, 'h60, "R8"); wr(0, 'h55, "R8"); rd('h100, 4, "R8");

    // buffered write with count masking and confirm
    wr(0, 'h50, "R9");
    wr('h300, 'hE8, "R9");
    rd(0, 4, "R9");
    wr('h300, 'hABCD0002, "R9");
    wr('h300, 'h01020304, "R9");
    wr('h304, 'h05060708, "R9");
    wr('h308, 'h090A0B0C, "R9");
    wr('h300, 'hD0, "R9");
    rd(0, 4, "R9");
    wr(0, 'hFF, "R9");
    rd('h300, 4, "R9"); rd('h304, 4, "R9"); rd('h308, 4, "R9");
    wr('h30C, 'hE8, "R9");
    wr('h30C, 'h0, "R9");
    wr('h30C, 'h77665544, "R9");
    wr('h30C, 'h77, "R9");
    rd('h30C, 4, "R9");

    // secure attribute
    wr(0, 'h70, "R11");
    xact(1'b0, 'h300, 0, 4, 1'b0, "R11");
    rd(0, 4, "R11");
    xact(1'b1, 0, 'h50, 4, 1'b0, "R11");
    rd(0, 4, "R11");
    xact(1'b1, 0, 'hFF, 4, 1'b0, "R11");
    rd(0, 4, "R11");
    wr(0, 'hFF, "R11");

    // response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h304; req_size = 2'd2; req_secure = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    held = m_arr('h304, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R13", "rsp_valid held", {31'h0, rsp_valid}, 32'h1);
      chk("R13", "rsp_rdata held", rsp_rdata, held);
      chk("R13", "req_ready low", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R13", "rsp drained", {31'h0, rsp_valid}, 32'h0);
    rd('h308, 4, "R13");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule